// File: doc/BRIEF.md
# Audio DAC Power-Up and Mute Sequencer

This block is the control sequencer of a stereo audio converter. It runs on the master clock and holds the converter in reset while the reset pin is low. After release it waits in a low-power state, counting frame-clock periods, and the length of that wait depends on the selected speed mode. It then times a fixed power-up ramp on the master clock and finally declares normal operation.

Two mute-control outputs, one per channel, drive external analog mute circuits. They stay asserted during reset and the whole power-up sequence. While running, each one follows its channel's soft-mute request. Both assert whenever the frame clock stops. A missing frame clock, or a new speed-mode selection, sends the sequencer back to the low-power wait. The de-emphasis request reaches the datapath only in single-speed mode.

A one-hot state vector and a ready flag make every transition visible at the ports.

Top module: `dac_pwr_seq`

## Requirements
- R1: While `rst_ni` is low the state is reset (`state_o` = 4'b0001), `ready_o` is 0, both mute outputs are 1, `deemph_o` is 0 and the latched speed returns to single-speed.
- R2: On the first clock after reset release the state becomes wait. It stays in wait until it has seen BASE_WAIT frame-clock rising edges for speed 2'b00 (single), 2×BASE_WAIT for 2'b01 (double), or 4×BASE_WAIT for 2'b10 or 2'b11 (quad). It then moves to ramp.
- R3: Ramp lasts exactly RAMP_CYCLES master-clock cycles and is followed by run. Ramp is entered only from wait, and run only from ramp.
- R4: In every state other than run, both mute outputs are 1.
- R5: In run with the frame clock present, `mute_o[0]` (channel A) equals `mute_req_i[0]` and `mute_o[1]` (channel B) equals `mute_req_i[1]`, each channel independent of the other.
- R6: If LOSS_CYCLES master-clock cycles pass with no frame-clock rising edge, the frame clock counts as lost. Both mutes assert and the state returns to wait on the next clock. The edge that ends the loss is not counted, and the wait count starts afresh from the edge after it.
- R7: `deemph_o` equals `deemph_req_i` only when the latched speed is single-speed (2'b00) and the state is not reset. Otherwise it is 0.
- R8: A change of `speed_i` in any state other than reset latches the new speed and returns the state to wait on the next clock, with the wait count cleared and the mutes asserted.
- R9: `state_o` is one-hot, with bit 0 reset, bit 1 wait, bit 2 ramp and bit 3 run. `ready_o` is 1 only in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low asynchronous reset pin |
| lrck_i | input | 1 | Left/right frame clock, asynchronous to clk_i |
| speed_i | input | 2 | Speed mode: 00 single, 01 double, 1x quad |
| mute_req_i | input | 2 | Soft-mute request, bit 0 channel A, bit 1 channel B |
| deemph_req_i | input | 1 | De-emphasis request |
| state_o | output | 4 | One-hot state: reset, wait, ramp, run |
| ready_o | output | 1 | Normal operation reached |
| mute_o | output | 2 | Mute-control outputs, bit 0 channel A, bit 1 channel B |
| deemph_o | output | 1 | Gated de-emphasis enable to the datapath |

## Verification
A wait counter that is wrong shows up as a ramp that starts one or more frame periods early or late. Such an error is visible at `state_o` about three master clocks after the frame-clock edge in question. A ramp counter that is off moves the rise of `ready_o` by the same number of master clocks. A stuck state, or a missed restart after loss or a speed change, leaves `mute_o` low, or `state_o` outside wait, on the clock after the cause. Gating faults appear on `mute_o` and `deemph_o` in the same cycle as the request changes, because those outputs are combinational from registered state.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  typedef enum logic [1:0] {
    ST_RESET = 2'd0,
    ST_WAIT  = 2'd1,
    ST_RAMP  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;

  localparam int NUM_STATES = 4;
  localparam logic [1:0] SPD_SINGLE = 2'b00;
  localparam logic [1:0] SPD_DOUBLE = 2'b01;
endpackage

// File: rtl/lrck_monitor.sv
module lrck_monitor #(
  parameter int LOSS_CYCLES = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lrck_i,
  output logic rise_o,
  output logic lost_o
);
  localparam int LCNT_W = $clog2(LOSS_CYCLES + 1);
  localparam logic [LCNT_W-1:0] LOSS_LAST = LCNT_W'(LOSS_CYCLES - 1);

  logic [2:0]        sync_q;
  logic [LCNT_W-1:0] idle_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], lrck_i};
  end

  assign rise_o = sync_q[1] & ~sync_q[2];

  // idle counter saturates at the loss threshold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idle_cnt_q <= '0;
      lost_o     <= 1'b0;
    end else if (rise_o) begin
      idle_cnt_q <= '0;
      lost_o     <= 1'b0;
    end else if (idle_cnt_q == LOSS_LAST) begin
      lost_o     <= 1'b1;
    end else begin
      idle_cnt_q <= idle_cnt_q + LCNT_W'(1);
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import dac_seq_pkg::*;
#(
  parameter int BASE_WAIT   = 512,
  parameter int RAMP_CYCLES = 614
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rise_i,
  input  logic       lost_i,
  input  logic [1:0] speed_i,
  output seq_state_e state_o,
  output logic [1:0] speed_q_o
);
  localparam int WCNT_W = $clog2(BASE_WAIT * 4 + 1);
  localparam int RCNT_W = $clog2(RAMP_CYCLES + 1);
  localparam logic [RCNT_W-1:0] RAMP_LAST = RCNT_W'(RAMP_CYCLES - 1);

  seq_state_e        state_q;
  logic [1:0]        speed_q;
  logic [WCNT_W-1:0] wcnt_q, target;
  logic [RCNT_W-1:0] rcnt_q;

  always_comb begin
    case (speed_q)
      SPD_SINGLE: target = WCNT_W'(BASE_WAIT);
      SPD_DOUBLE: target = WCNT_W'(BASE_WAIT * 2);
      default:    target = WCNT_W'(BASE_WAIT * 4);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RESET;
      speed_q <= SPD_SINGLE;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else if (state_q == ST_RESET) begin
      state_q <= ST_WAIT;
      speed_q <= speed_i;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else if (speed_i != speed_q) begin
      speed_q <= speed_i;
      state_q <= ST_WAIT;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else if (lost_i) begin
      // hold the wait count clear until the frame clock is back
      state_q <= ST_WAIT;
      wcnt_q  <= '0;
      rcnt_q  <= '0;
    end else begin
      case (state_q)
        ST_WAIT: if (rise_i) begin
          if (wcnt_q == target - WCNT_W'(1)) begin
            state_q <= ST_RAMP;
            wcnt_q  <= '0;
            rcnt_q  <= '0;
          end else begin
            wcnt_q <= wcnt_q + WCNT_W'(1);
          end
        end
        ST_RAMP: begin
          if (rcnt_q == RAMP_LAST) state_q <= ST_RUN;
          else                     rcnt_q  <= rcnt_q + RCNT_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign state_o   = state_q;
  assign speed_q_o = speed_q;
endmodule

// File: rtl/out_gate.sv
module out_gate #(
  parameter int CHANNELS = 2
) (
  input  logic                force_mute_i,
  input  logic [CHANNELS-1:0] mute_req_i,
  input  logic                deemph_allow_i,
  input  logic                deemph_req_i,
  output logic [CHANNELS-1:0] mute_o,
  output logic                deemph_o
);
  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    assign mute_o[c] = force_mute_i | mute_req_i[c];
  end

  assign deemph_o = deemph_allow_i & deemph_req_i;
endmodule

// File: rtl/dac_pwr_seq.sv
module dac_pwr_seq
  import dac_seq_pkg::*;
#(
  parameter int MCLK_HZ     = 12_288_000,
  parameter int BASE_WAIT   = 512,
  parameter int RAMP_CYCLES = MCLK_HZ / 20_000,
  parameter int LOSS_CYCLES = 2048,
  parameter int CHANNELS    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                lrck_i,
  input  logic [1:0]          speed_i,
  input  logic [CHANNELS-1:0] mute_req_i,
  input  logic                deemph_req_i,
  output logic [3:0]          state_o,
  output logic                ready_o,
  output logic [CHANNELS-1:0] mute_o,
  output logic                deemph_o
);
  seq_state_e state;
  logic       frame_rise, frame_lost;
  logic [1:0] speed_q;
  logic       running;

  lrck_monitor #(.LOSS_CYCLES(LOSS_CYCLES)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lrck_i (lrck_i),
    .rise_o (frame_rise),
    .lost_o (frame_lost)
  );

  seq_fsm #(.BASE_WAIT(BASE_WAIT), .RAMP_CYCLES(RAMP_CYCLES)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (frame_rise),
    .lost_i    (frame_lost),
    .speed_i   (speed_i),
    .state_o   (state),
    .speed_q_o (speed_q)
  );

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_onehot
    assign state_o[s] = (state == seq_state_e'(s));
  end

  assign running = (state == ST_RUN);
  assign ready_o = running;

  out_gate #(.CHANNELS(CHANNELS)) u_gate (
    .force_mute_i   (~running | frame_lost),
    .mute_req_i     (mute_req_i),
    .deemph_allow_i ((speed_q == SPD_SINGLE) && (state != ST_RESET)),
    .deemph_req_i   (deemph_req_i),
    .mute_o         (mute_o),
    .deemph_o       (deemph_o)
  );
endmodule

// File: rtl/dac_pwr_seq_chk.sv
module dac_pwr_seq_chk #(
  parameter int CHANNELS = 2
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [1:0]          speed_i,
  input logic [1:0]          speed_q,
  input logic                frame_lost,
  input logic [CHANNELS-1:0] mute_req_i,
  input logic                deemph_req_i,
  input logic [3:0]          state_o,
  input logic                ready_o,
  input logic [CHANNELS-1:0] mute_o,
  input logic                deemph_o
);
  p_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);

  p_ready_run_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> state_o == 4'b1000);

  p_mute_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_o[3] |-> &mute_o);

  p_mute_lost_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_lost |-> &mute_o);

  p_lost_to_wait_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_lost && !state_o[0]) |=> state_o[1]);

  p_release_to_wait_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(state_o[0]) |-> state_o[1]);

  p_ramp_from_wait_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o[2]) |-> $past(state_o[1]));

  p_run_from_ramp_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_o[3]) |-> $past(state_o[2]));

  p_speed_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!state_o[0] && speed_i != speed_q) |=> state_o[1]);

  p_deemph_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deemph_o |-> deemph_req_i);

  p_deemph_fast_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_i != 2'b00 && $past(speed_i) != 2'b00) |-> !deemph_o);
endmodule

bind dac_pwr_seq dac_pwr_seq_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .speed_i      (speed_i),
  .speed_q      (speed_q),
  .frame_lost   (frame_lost),
  .mute_req_i   (mute_req_i),
  .deemph_req_i (deemph_req_i),
  .state_o      (state_o),
  .ready_o      (ready_o),
  .mute_o       (mute_o),
  .deemph_o     (deemph_o)
);

// File: tb/dac_pwr_seq_bench.sv
module dac_pwr_seq_bench;
  localparam int BW   = 8;
  localparam int RC   = 20;
  localparam int LC   = 64;
  localparam int HALF = 4;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       lrck_i;
  logic [1:0] speed_i;
  logic [1:0] mute_req_i;
  logic       deemph_req_i;
  logic [3:0] state_o;
  logic       ready_o;
  logic [1:0] mute_o;
  logic       deemph_o;

  int  n_chk = 0;
  int  n_bad = 0;
  int  frames_sent = 0;
  bit  lr_en = 1'b0;
  bit  done = 1'b0;

  always #4 clk_i = ~clk_i;

  dac_pwr_seq #(
    .BASE_WAIT(BW), .RAMP_CYCLES(RC), .LOSS_CYCLES(LC), .CHANNELS(2)
  ) u_dac_pwr_seq (
    .clk_i, .rst_ni, .lrck_i, .speed_i, .mute_req_i, .deemph_req_i,
    .state_o, .ready_o, .mute_o, .deemph_o
  );

  function automatic int wait_len(input logic [1:0] spd);
    return spd == 2'b00 ? BW : (spd == 2'b01 ? 2 * BW : 4 * BW);
  endfunction

  function automatic logic [1:0] exp_mute(input logic run, input logic [1:0] req);
    return run ? req : 2'b11;
  endfunction

  function automatic logic exp_deemph(input logic [1:0] spd, input logic req);
    return (spd == 2'b00) & req;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_bench();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // frame clock generator: period 2*HALF master clocks
  initial begin
    lrck_i = 1'b0;
    forever begin
      @(negedge clk_i);
      if (lr_en) begin
        lrck_i = 1'b1;
        frames_sent++;
        repeat (HALF) @(negedge clk_i);
        lrck_i = 1'b0;
        repeat (HALF - 1) @(negedge clk_i);
      end
    end
  end

  // wait for n counted frames, check wait just before, ramp/run after
  task automatic run_wait(input int n, input string tag);
    int k;
    wait (frames_sent == n - 1);
    repeat (6) @(negedge clk_i);
    chk({"R2 still wait ", tag}, state_o, 4'b0010);
    chk({"R4 mute in wait ", tag}, mute_o, 2'b11);
    wait (frames_sent == n);
    k = 0;
    @(negedge clk_i);
    while (state_o != 4'b0100 && k < 12) begin
      @(negedge clk_i);
      k++;
    end
    chk({"R2 ramp entered ", tag}, state_o, 4'b0100);
    chk({"R2 ramp latency ", tag}, 32'(k < 6), 32'd1);
    repeat (RC - 2) @(negedge clk_i);
    chk({"R3 ramp length ", tag}, state_o, 4'b0100);
    chk({"R4 mute in ramp ", tag}, mute_o, 2'b11);
    repeat (3) @(negedge clk_i);
    chk({"R3 run ", tag}, state_o, 4'b1000);
    chk({"R9 ready ", tag}, ready_o, 1'b1);
  endtask

  task automatic random_run(input int iters, input logic [1:0] spd);
    for (int i = 0; i < iters; i++) begin
      @(negedge clk_i);
      mute_req_i   = 2'($urandom);
      deemph_req_i = 1'($urandom);
      #2;
      chk("R5 mute follows request", mute_o, exp_mute(1'b1, mute_req_i));
      chk("R7 deemph gate", deemph_o, exp_deemph(spd, deemph_req_i));
    end
  endtask

  initial begin
    repeat (100_000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_bench();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_ni = 1'b0;
    speed_i = 2'b00;
    mute_req_i = 2'b00;
    deemph_req_i = 1'b1;
    repeat (5) @(negedge clk_i);
    chk("R1 reset state", state_o, 4'b0001);
    chk("R1 ready low", ready_o, 1'b0);
    chk("R1 mute high", mute_o, 2'b11);
    chk("R1 deemph off", deemph_o, 1'b0);

    // single-speed bring-up
    rst_ni = 1'b1;
    frames_sent = 0;
    lr_en = 1'b1;
    @(negedge clk_i);
    chk("R2 wait after release", state_o, 4'b0010);
    run_wait(wait_len(2'b00), "single");
    random_run(60, 2'b00);
    mute_req_i = 2'b01;
    #1 chk("R5 channel A only", mute_o, 2'b01);
    mute_req_i = 2'b10;
    #1 chk("R5 channel B only", mute_o, 2'b10);

    // speed change to double while running
    lr_en = 1'b0;
    repeat (12) @(negedge clk_i);
    speed_i = 2'b01;
    deemph_req_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R8 restart to wait", state_o, 4'b0010);
    chk("R8 mute on restart", mute_o, 2'b11);
    chk("R7 deemph off double", deemph_o, 1'b0);
    frames_sent = 0;
    lr_en = 1'b1;
    run_wait(wait_len(2'b01), "double");
    random_run(40, 2'b01);

    // frame clock loss
    lr_en = 1'b0;
    repeat (LC + 20) @(negedge clk_i);
    chk("R6 loss to wait", state_o, 4'b0010);
    chk("R6 loss mutes", mute_o, 2'b11);
    chk("R6 ready dropped", ready_o, 1'b0);
    frames_sent = 0;
    lr_en = 1'b1;
    run_wait(wait_len(2'b01) + 1, "after loss");

    // reset mid-run, then quad via code 11
    @(negedge clk_i);
    rst_ni = 1'b0;
    lr_en = 1'b0;
    speed_i = 2'b11;
    deemph_req_i = 1'b1;
    repeat (12) @(negedge clk_i);
    chk("R1 reset mid-run", state_o, 4'b0001);
    chk("R1 mute in reset", mute_o, 2'b11);
    chk("R1 deemph in reset", deemph_o, 1'b0);
    rst_ni = 1'b1;
    frames_sent = 0;
    lr_en = 1'b1;
    run_wait(wait_len(2'b11), "quad");
    random_run(40, 2'b11);

    finish_bench();
  end
endmodule